// File: doc/BRIEF.md
# Host Parallel Port Control

This block is the host-facing control logic of an 8-bit parallel port that carries 24-bit words between an external host and a processor core. The host reaches a small register file through a 3-bit address with single-cycle read and write strobes. One address holds a control register with a self-clearing initialize command, a byte-order select, two host-owned flags and a request-pin mode select. Another address reports the host-side transfer status. Three addresses carry the bytes of the data word.

Each direction has a source register and a destination register. A source holds a word until the destination is empty, then passes the word on in one cycle. The host completes an outgoing word by writing its low byte, and it frees an incoming word by reading its low byte. The core side has a 24-bit write port, a 24-bit read port, its two flags, and read-only copies of the host flags. Two request pins report whether a transfer is wanted, either merged into one pin or split into one pin per direction.

Top module: `hpc_host_port`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00. The host status register (address 2) reads 0x02 (bit 1 = host transmit empty = 1, bit 0 = host receive full = 0). `core_rx_full` is 0 and `core_tx_empty` is 1.
- R2: The control register has these bits: 7 initialize, 5 byte order, 4 host flag 1, 3 host flag 0, 2 split-request mode, 1 transmit-request enable, 0 receive-request enable. Bits 5..0 read back as written. Bits 7 and 6 always read 0.
- R3: A control write with bit 7 set and bits 1..0 = 00 leaves all four transfer flags unchanged.
- R4: A control write with bit 7 set and bit 0 set clears `core_rx_full` and sets host transmit empty at that clock edge.
- R5: A control write with bit 7 set and bit 1 set sets `core_tx_empty` and clears host receive full at that clock edge.
- R6: A control write with bit 7 set and bits 1..0 = 11 makes all four updates of R4 and R5 together.
- R7: With byte order 0, the high, middle and low data bytes are at addresses 5, 6 and 7. With byte order 1, they are at addresses 7, 6 and 5.
- R8: A host write to the low-byte address clears host transmit empty. One cycle later, if `core_rx_full` is 0, the word moves to `core_rx_data`, `core_rx_full` is set and host transmit empty is set again. While `core_rx_full` is 1, the word waits until a `core_rx_rd` pulse clears the flag.
- R9: A `core_tx_wr` pulse clears `core_tx_empty`. The word moves to the host receive register one cycle later if host receive full is 0. A host read strobe at the low-byte address clears host receive full, and a waiting core word reloads on the next cycle.
- R10: `core_hf0` and `core_hf1` follow control bits 3 and 4 from the edge of the host write. No other event changes them.
- R11: With bit 2 = 0, `req_a` = (bit1 AND transmit empty) OR (bit0 AND receive full), `req_b` = 0 and `req_b_oe` = 0. With bit 2 = 1, `req_a` = bit1 AND transmit empty, `req_b` = bit0 AND receive full and `req_b_oe` = 1.
- R12: Writes to addresses 1, 2, 3 and 4 have no effect. Addresses 1, 3 and 4 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle (pops on the low-byte address) |
| host_rdata | output | 8 | Host read data, combinational from `host_addr` |
| core_tx_wr | input | 1 | Core loads a word for the host |
| core_tx_data | input | 24 | Word from the core |
| core_rx_rd | input | 1 | Core takes the received word |
| core_rx_data | output | 24 | Word delivered to the core |
| core_rx_full | output | 1 | Core receive register holds a word |
| core_tx_empty | output | 1 | Core transmit register can take a word |
| core_hf0 | output | 1 | Read-only copy of host flag 0 |
| core_hf1 | output | 1 | Read-only copy of host flag 1 |
| req_a | output | 1 | Merged request, or transmit request in split mode |
| req_b | output | 1 | Receive request in split mode |
| req_b_oe | output | 1 | Drive enable for the second request pin |

## Verification
On every cycle, the assertions check the flag effects of an initialize command for each enabled direction. They also check that the host flags follow only host writes, that a low-byte write empties the host transmit side, and that a delivered core word holds until it is consumed. The byte placement for both orders, the reload after a pop, back-pressure when a destination is still full, the request-pin levels in both modes, and the unmapped addresses having no effect can only be shown by the bench scenarios. The bench compares these against values it computes itself.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  localparam int BYTE_W  = 8;
  localparam int N_LANES = 3;
  localparam int WORD_W  = BYTE_W * N_LANES;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DFIRST = 3'd5;
  localparam logic [ADDR_W-1:0] A_DMID   = 3'd6;
  localparam logic [ADDR_W-1:0] A_DLAST  = 3'd7;

  typedef enum logic [1:0] {
    LANE_LO   = 2'd0,
    LANE_MID  = 2'd1,
    LANE_HI   = 2'd2,
    LANE_NONE = 2'd3
  } lane_e;

  // Packed so that hlend lands on bit 5 and rreq on bit 0 of the register.
  typedef struct packed {
    logic hlend;
    logic hf1;
    logic hf0;
    logic hdrq;
    logic treq;
    logic rreq;
  } ctrl_t;

  // Byte lane that a host address selects under a given byte order.
  function automatic lane_e lane_of(input logic [ADDR_W-1:0] a, input logic le);
    lane_e l;
    case (a)
      A_DFIRST: l = le ? LANE_LO : LANE_HI;
      A_DMID:   l = LANE_MID;
      A_DLAST:  l = le ? LANE_HI : LANE_LO;
      default:  l = LANE_NONE;
    endcase
    return l;
  endfunction

  // Readback image: initialize and reserved bits always read zero.
  function automatic logic [BYTE_W-1:0] ctrl_image(input ctrl_t c);
    return {2'b00, c};
  endfunction

  function automatic logic tx_want(input ctrl_t c, input logic tx_empty);
    return c.treq & tx_empty;
  endfunction

  function automatic logic rx_want(input ctrl_t c, input logic rx_full);
    return c.rreq & rx_full;
  endfunction

endpackage

// File: rtl/hpc_ctrl_reg.sv
module hpc_ctrl_reg
  import hpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  init_bit,
  input  logic [5:0] fields,
  output ctrl_t ctrl,
  output logic  init_fire
);

  // The initialize command runs at the edge of the write itself, so the
  // command bit never has to be stored and always reads back as zero.
  assign init_fire = wr_en & init_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl <= ctrl_t'(fields);
    end
  end

endmodule

// File: rtl/hpc_xfer.sv
module hpc_xfer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_dir,
  input  logic         src_wr,
  input  logic [W-1:0] src_data,
  input  logic         dst_rd,
  output logic         src_empty,
  output logic         dst_full,
  output logic [W-1:0] dst_data,
  output logic         move
);

  logic [W-1:0] src_q;

  // A word passes on whenever the source holds one and the destination is free.
  assign move = !init_dir && !src_empty && !dst_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q     <= '0;
      src_empty <= 1'b1;
      dst_full  <= 1'b0;
      dst_data  <= '0;
    end else if (init_dir) begin
      // Initialize has priority over any same-cycle load or consume.
      src_empty <= 1'b1;
      dst_full  <= 1'b0;
    end else begin
      if (src_wr) begin
        src_q     <= src_data;
        src_empty <= 1'b0;
      end else if (move) begin
        src_empty <= 1'b1;
      end
      if (move) begin
        dst_data <= src_q;
        dst_full <= 1'b1;
      end else if (dst_rd) begin
        dst_full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hpc_req_mux.sv
module hpc_req_mux
  import hpc_pkg::*;
(
  input  ctrl_t ctrl,
  input  logic  tx_empty,
  input  logic  rx_full,
  output logic  req_a,
  output logic  req_b,
  output logic  req_b_oe
);

  logic want_tx;
  logic want_rx;

  assign want_tx = tx_want(ctrl, tx_empty);
  assign want_rx = rx_want(ctrl, rx_full);

  always_comb begin
    if (ctrl.hdrq) begin
      req_a    = want_tx;
      req_b    = want_rx;
      req_b_oe = 1'b1;
    end else begin
      req_a    = want_tx | want_rx;
      req_b    = 1'b0;
      req_b_oe = 1'b0;
    end
  end

endmodule

// File: rtl/hpc_host_port.sv
module hpc_host_port
  import hpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              core_tx_wr,
  input  logic [WORD_W-1:0] core_tx_data,
  input  logic              core_rx_rd,
  output logic [WORD_W-1:0] core_rx_data,
  output logic              core_rx_full,
  output logic              core_tx_empty,
  output logic              core_hf0,
  output logic              core_hf1,
  output logic              req_a,
  output logic              req_b,
  output logic              req_b_oe
);

  ctrl_t ctrl;
  logic  ctrl_wr;
  logic  init_fire;
  logic  hlend;
  lane_e sel;

  // Named internal events, visible to the bound checker.
  logic  htx_commit;
  logic  hrx_pop;
  logic  htx_empty;
  logic  hrx_full;
  logic  h2c_move;
  logic  c2h_move;
  logic  h2c_init;
  logic  c2h_init;

  logic [N_LANES-1:1][BYTE_W-1:0] stage;
  logic [WORD_W-1:0]              htx_word;
  logic [WORD_W-1:0]              hrx_word;

  assign ctrl_wr    = host_wr && (host_addr == A_CTRL);
  assign hlend      = ctrl.hlend;
  assign sel        = lane_of(host_addr, hlend);
  assign htx_commit = host_wr && (sel == LANE_LO);
  assign hrx_pop    = host_rd && (sel == LANE_LO);
  assign h2c_init   = init_fire && ctrl_wr && host_wdata[0];
  assign c2h_init   = init_fire && ctrl_wr && host_wdata[1];

  hpc_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr),
    .init_bit  (host_wdata[7]),
    .fields    (host_wdata[5:0]),
    .ctrl      (ctrl),
    .init_fire (init_fire)
  );

  // Upper byte lanes are staged. The low-byte write completes the word.
  for (genvar g = 1; g < N_LANES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage[g] <= '0;
      end else if (host_wr && (sel == lane_e'(g))) begin
        stage[g] <= host_wdata;
      end
    end
  end

  assign htx_word = {stage, host_wdata};

  hpc_xfer #(.W(WORD_W)) u_h2c (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_dir  (h2c_init),
    .src_wr    (htx_commit),
    .src_data  (htx_word),
    .dst_rd    (core_rx_rd),
    .src_empty (htx_empty),
    .dst_full  (core_rx_full),
    .dst_data  (core_rx_data),
    .move      (h2c_move)
  );

  hpc_xfer #(.W(WORD_W)) u_c2h (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_dir  (c2h_init),
    .src_wr    (core_tx_wr),
    .src_data  (core_tx_data),
    .dst_rd    (hrx_pop),
    .src_empty (core_tx_empty),
    .dst_full  (hrx_full),
    .dst_data  (hrx_word),
    .move      (c2h_move)
  );

  hpc_req_mux u_req (
    .ctrl     (ctrl),
    .tx_empty (htx_empty),
    .rx_full  (hrx_full),
    .req_a    (req_a),
    .req_b    (req_b),
    .req_b_oe (req_b_oe)
  );

  assign core_hf0 = ctrl.hf0;
  assign core_hf1 = ctrl.hf1;

  always_comb begin
    host_rdata = '0;
    if (host_addr == A_CTRL) begin
      host_rdata = ctrl_image(ctrl);
    end else if (host_addr == A_STAT) begin
      host_rdata = {{(BYTE_W-2){1'b0}}, htx_empty, hrx_full};
    end else if (sel != LANE_NONE) begin
      host_rdata = hrx_word[BYTE_W*int'(sel) +: BYTE_W];
    end
  end

endmodule

// File: rtl/hpc_host_port_chk.sv
module hpc_host_port_chk
  import hpc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic              wr_init,
  input logic              wr_treq,
  input logic              wr_rreq,
  input logic              wr_hf0,
  input logic              wr_hf1,
  input logic              hlend,
  input logic              htx_empty,
  input logic              hrx_full,
  input logic              core_rx_full,
  input logic              core_tx_empty,
  input logic              core_rx_rd,
  input logic [WORD_W-1:0] core_rx_data,
  input logic              core_hf0,
  input logic              core_hf1,
  input logic              h2c_move
);

  logic              cwr;
  logic [ADDR_W-1:0] lo_addr;

  assign cwr     = host_wr && (host_addr == A_CTRL);
  assign lo_addr = hlend ? 3'd5 : 3'd7;

  AST_INIT_RX_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr && wr_init && wr_rreq) |=> (!core_rx_full && htx_empty)); // R4

  AST_INIT_TX_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr && wr_init && wr_treq) |=> (core_tx_empty && !hrx_full)); // R5

  AST_HF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cwr |=> (core_hf0 == $past(wr_hf0)) && (core_hf1 == $past(wr_hf1))); // R10

  AST_HF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cwr |=> ($stable(core_hf0) && $stable(core_hf1))); // R10

  AST_COMMIT_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_addr == lo_addr)) |=> !htx_empty); // R8

  AST_MOVE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (h2c_move && !cwr) |=> core_rx_full); // R8

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rx_full && !core_rx_rd && !cwr) |=> (core_rx_full && $stable(core_rx_data))); // R8

  AST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && (host_addr == lo_addr) && hrx_full) |=> !hrx_full); // R9

endmodule

bind hpc_host_port hpc_host_port_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_addr     (host_addr),
  .host_wr       (host_wr),
  .host_rd       (host_rd),
  .wr_init       (host_wdata[7]),
  .wr_treq       (host_wdata[1]),
  .wr_rreq       (host_wdata[0]),
  .wr_hf0        (host_wdata[3]),
  .wr_hf1        (host_wdata[4]),
  .hlend         (hlend),
  .htx_empty     (htx_empty),
  .hrx_full      (hrx_full),
  .core_rx_full  (core_rx_full),
  .core_tx_empty (core_tx_empty),
  .core_rx_rd    (core_rx_rd),
  .core_rx_data  (core_rx_data),
  .core_hf0      (core_hf0),
  .core_hf1      (core_hf1),
  .h2c_move      (h2c_move)
);

// File: tb/tb_hpc_host_port.sv
module tb_hpc_host_port;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  host_addr;
  logic [7:0]  host_wdata;
  logic        host_wr;
  logic        host_rd;
  logic [7:0]  host_rdata;
  logic        core_tx_wr;
  logic [23:0] core_tx_data;
  logic        core_rx_rd;
  logic [23:0] core_rx_data;
  logic        core_rx_full;
  logic        core_tx_empty;
  logic        core_hf0;
  logic        core_hf1;
  logic        req_a;
  logic        req_b;
  logic        req_b_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hpc_host_port dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; host_addr = '0; host_wdata = '0; host_wr = 1'b0; host_rd = 1'b0;
    core_tx_wr = 1'b0; core_tx_data = '0; core_rx_rd = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic hpeek(input logic [2:0] a, output logic [7:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic hpop(input logic [2:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1; #1; d = host_rdata;
    tick();
    host_rd = 1'b0;
  endtask

  task automatic cwr(input logic [23:0] w);
    core_tx_data = w; core_tx_wr = 1'b1;
    tick();
    core_tx_wr = 1'b0;
  endtask

  task automatic crd();
    core_rx_rd = 1'b1;
    tick();
    core_rx_rd = 1'b0;
  endtask

  // Byte order 0: high at 5, low at 7. Byte order 1: high at 7, low at 5.
  function automatic logic [2:0] hi_addr(input bit le);
    return le ? 3'd7 : 3'd5;
  endfunction

  function automatic logic [2:0] lo_addr(input bit le);
    return le ? 3'd5 : 3'd7;
  endfunction

  task automatic hword(input logic [23:0] w, input bit le);
    hwr(hi_addr(le), w[23:16]);
    hwr(3'd6, w[15:8]);
    hwr(lo_addr(le), w[7:0]);
  endtask

  function automatic logic [23:0] pat(input int i, input bit le);
    return (24'h010203 * 24'(i + 1)) ^ (le ? 24'hA5C35A : 24'h3C9617);
  endfunction

  task automatic set_state(input int st);
    do_reset();
    if (st >= 2) begin
      hword(24'h111111, 1'b0); tick();
      hword(24'h222222, 1'b0);
    end
    if (st == 1 || st == 3) begin
      cwr(24'h333333); tick();
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    report();
    $finish;
  end

  initial begin
    logic [7:0] d;
    string tag;

    // R1 reset state
    do_reset();
    hpeek(3'd0, d); check("R1 ctrl", d, 8'h00);
    hpeek(3'd2, d); check("R1 status", d, 8'h02);
    check("R1 core_rx_full", core_rx_full, 0);
    check("R1 core_tx_empty", core_tx_empty, 1);
    check("R1 req_a", req_a, 0);

    // R2 / R10 control register sweep over all byte values
    for (int v = 0; v < 256; v++) begin
      hwr(3'd0, 8'(v));
      hpeek(3'd0, d); check("R2 readback", d, {2'b00, 6'(v)});
      check("R10 hf0", core_hf0, (v >> 3) & 1);
      check("R10 hf1", core_hf1, (v >> 4) & 1);
      hpeek(3'd2, d); check("R3 status idle", d, 8'h02);
    end

    // R3..R6 initialize with every direction combination from a busy state
    for (int c = 0; c < 4; c++) begin
      set_state(3);
      hword(24'h444444, 1'b0); // keeps a host word waiting behind a full core register
      cwr(24'h555555);         // keeps a core word waiting behind a full host register
      hpeek(3'd2, d); check("R8 busy status", d, 8'h01);
      check("R9 busy core_tx_empty", core_tx_empty, 0);
      tag = (c == 0) ? "R3" : (c == 1) ? "R4" : (c == 2) ? "R5" : "R6";
      hwr(3'd0, 8'h80 | 8'(c));
      check({tag, " core_rx_full"}, core_rx_full, (c & 1) ? 0 : 1);
      check({tag, " core_tx_empty"}, core_tx_empty, (c & 2) ? 1 : 0);
      hpeek(3'd2, d);
      check({tag, " status"}, d, {6'b0, 1'((c & 1) != 0), 1'((c & 2) == 0)});
      hpeek(3'd0, d); check({tag, " init reads 0"}, d, 8'(c));
    end

    // R7 / R8 host-to-core words in both byte orders
    for (int le = 0; le < 2; le++) begin
      do_reset();
      hwr(3'd0, le ? 8'h20 : 8'h00);
      for (int i = 0; i < 16; i++) begin
        hword(pat(i, 1'(le)), 1'(le));
        hpeek(3'd2, d); check("R8 commit clears empty", d[1], 0);
        tick();
        check("R8 delivered", core_rx_full, 1);
        check("R7 word order h2c", core_rx_data, pat(i, 1'(le)));
        hpeek(3'd2, d); check("R8 empty again", d[1], 1);
        crd();
        check("R8 consumed", core_rx_full, 0);
      end
    end

    // R7 / R9 core-to-host words in both byte orders
    for (int le = 0; le < 2; le++) begin
      do_reset();
      hwr(3'd0, le ? 8'h20 : 8'h00);
      for (int i = 0; i < 16; i++) begin
        logic [23:0] w;
        w = pat(i + 20, 1'(le));
        cwr(w); tick();
        hpeek(3'd2, d); check("R9 host full", d[0], 1);
        hpeek(hi_addr(1'(le)), d); check("R7 high byte", d, w[23:16]);
        hpeek(3'd6, d); check("R7 mid byte", d, w[15:8]);
        hpop(lo_addr(1'(le)), d); check("R7 low byte", d, w[7:0]);
        hpeek(3'd2, d); check("R9 pop clears", d, 8'h02);
      end
    end

    // R8 back-pressure on the core receive side
    do_reset();
    hword(24'hABCDEF, 1'b0); tick();
    hword(24'h123456, 1'b0); tick(); tick();
    check("R8 first held", core_rx_data, 24'hABCDEF);
    hpeek(3'd2, d); check("R8 second waiting", d[1], 0);
    crd();
    check("R8 cleared by core read", core_rx_full, 0);
    tick();
    check("R8 second delivered", core_rx_data, 24'h123456);
    check("R8 second full", core_rx_full, 1);
    hpeek(3'd2, d); check("R8 empty after move", d[1], 1);

    // R9 reload after a host pop
    do_reset();
    cwr(24'h0A0B0C); tick();
    cwr(24'h0D0E0F); tick();
    check("R9 core word waiting", core_tx_empty, 0);
    hpop(3'd7, d); check("R9 first low byte", d, 8'h0C);
    hpeek(3'd2, d); check("R9 cleared", d[0], 0);
    tick();
    hpeek(3'd2, d); check("R9 reloaded", d[0], 1);
    hpeek(3'd5, d); check("R9 reload high byte", d, 8'h0D);
    check("R9 core empty again", core_tx_empty, 1);

    // R12 unmapped and read-only addresses ignore writes
    do_reset();
    hwr(3'd0, 8'h3B);
    for (int a = 1; a < 5; a++) hwr(3'(a), 8'hFF);
    for (int a = 1; a < 5; a++) begin
      if (a != 2) begin
        hpeek(3'(a), d); check("R12 reads zero", d, 8'h00);
      end
    end
    hpeek(3'd0, d); check("R12 ctrl untouched", d, 8'h3B);
    hpeek(3'd2, d); check("R12 status untouched", d, 8'h02);
    check("R12 core flags untouched", {core_rx_full, core_tx_empty}, 2'b01);

    // R11 request pins over all flag states and control bits 5..0
    for (int st = 0; st < 4; st++) begin
      bit te, rf;
      te = (st < 2);
      rf = (st == 1 || st == 3);
      set_state(st);
      hpeek(3'd2, d); check("R11 state setup", d, {6'b0, te, rf});
      for (int v = 0; v < 64; v++) begin
        bit sp, t, r, ea, eb;
        sp = v[2]; t = v[1]; r = v[0];
        ea = sp ? (t & te) : ((t & te) | (r & rf));
        eb = sp ? (r & rf) : 1'b0;
        hwr(3'd0, 8'(v));
        check("R11 req_a", req_a, ea);
        check("R11 req_b", req_b, eb);
        check("R11 req_b_oe", req_b_oe, sp);
      end
    end

    report();
    $finish;
  end

endmodule